// File: doc/BRIEF.md
# Burst-Capable Serial Converter Sampling Controller

This block is the host side of a link to a serial analog-to-digital converter whose power state is set by how long chip select stays low within a frame. The block drives chip select and a serial clock and shifts in 16-bit results most-significant bit first. It delivers each finished word on a result bus together with a one-cycle strobe.

A single command starts the work. In continuous mode the block runs full conversion frames one after another until it is told to stop. In burst mode it first sends a wake-up frame whose data is discarded. It then runs a programmed number of conversions and finally sends a short frame that puts the converter to sleep. The serial clock half-period, the quiet gap between frames and the burst length are taken from input ports when the command is accepted. The frame lengths used for sleep and wake-up are fixed by parameters.

Top module: `adc_burst_sampler`

## Requirements
- R1: While reset is held and on the first cycle after it, adc_cs_n and adc_sclk are 1 and busy and result_valid are 0.
- R2: A command (cmd_valid high) is accepted only while busy is 0. At that cycle div_half, quiet_cycles, burst_count and cmd_burst are captured. Later changes on those ports, and cmd_valid pulses while busy is 1, have no effect on the running command.
- R3: adc_sclk is 1 whenever adc_cs_n is 1. Each high and each low half of the serial clock lasts div_half system clocks, and a div_half of 0 acts as 1. Every frame begins with a high half.
- R4: adc_sdata is sampled on the system clock in which adc_sclk falls, and the first sample goes to result bit 15. When the 16th sample of a conversion frame is taken, result is loaded and result_valid is 1 for exactly that one cycle. result_valid is never 1 while adc_cs_n is 1.
- R5: A conversion frame holds adc_cs_n low for exactly 16 falling edges of adc_sclk. adc_cs_n returns to 1 in the same cycle that adc_sclk rises after the 16th falling edge.
- R6: Between two frames of one command, adc_cs_n stays 1 for exactly quiet_cycles+1 system clocks.
- R7: With cmd_burst 0, the block issues conversion frames back to back. A cmd_stop pulse seen while busy lets the current frame and its quiet gap finish, and then no further frame starts.
- R8: With cmd_burst 1, the block issues one wake-up frame, then burst_count conversion frames, then one sleep frame. A burst_count of 0 gives a wake-up frame followed directly by a sleep frame.
- R9: The wake-up frame ends after K falling edges, where K = max(WAKE_MIN, ceil(PWRUP_CLKS / (2*div_half))), capped at 16 (defaults WAKE_MIN=10 and PWRUP_CLKS=200). The wake-up frame produces no result_valid.
- R10: The sleep frame ends after PD_EDGES falling edges (default 4, which must lie between 3 and 9 inclusive) and produces no result_valid.
- R11: busy rises in the cycle the command is accepted and falls when the quiet gap after the last frame has elapsed. adc_cs_n is 0 only while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command (accepted only when idle) |
| cmd_burst | input | 1 | 1 = burst with wake-up and sleep, 0 = continuous |
| cmd_stop | input | 1 | Ends continuous sampling after the current frame |
| div_half | input | DIV_W | Serial clock half-period in system clocks |
| quiet_cycles | input | Q_W | Quiet gap control: gap is this value plus one clocks |
| burst_count | input | CNT_W | Conversions per burst |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, parked high |
| result | output | DW | Last captured conversion word |
| result_valid | output | 1 | One-cycle strobe on a new result |
| busy | output | 1 | Command in progress |

## Verification
On every cycle the checker enforces these rules: the serial clock is parked high outside frames, the result strobe is one cycle long and falls inside a frame, chip select is low only while busy is high, the gap between frames of a command matches the captured quiet count, and each frame ends either at the sleep edge count or somewhere between the wake minimum and 16 edges. Other properties need whole command sequences, so only the bench scenarios show them. These include the exact order of wake-up, conversion and sleep frames, the wake-up length computed from the divider, the result words matching the bits the bench shifts in, the stop handling in continuous mode, and the way commands and port changes are ignored during a run.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW, ST_QUIET} seq_st_t;
  typedef enum logic [1:0] {FR_CONV, FR_WAKE, FR_SLEEP} frame_t;
endpackage

// File: rtl/adcs_phase_timer.sv
module adcs_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] ph;

  // tick marks the last system clock of a serial clock half
  assign tick = (ph == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) ph <= '0;
    else if (tick)  ph <= '0;
    else            ph <= ph + DIV_W'(1);
  end
endmodule

// File: rtl/adcs_rx_shift.sv
module adcs_rx_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic          publish,
  input  logic          sdata,
  output logic [DW-1:0] result,
  output logic          valid
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (sample) begin
        sh <= {sh[DW-2:0], sdata};
        if (publish) begin
          result <= {sh[DW-2:0], sdata};
          valid  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DIV_W      = 8,
  parameter int Q_W        = 8,
  parameter int CNT_W      = 8,
  parameter int PWRUP_CLKS = 200,
  parameter int PD_EDGES   = 4,
  parameter int WAKE_MIN   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_burst,
  input  logic             cmd_stop,
  input  logic [DIV_W-1:0] div_half,
  input  logic [Q_W-1:0]   quiet_cycles,
  input  logic [CNT_W-1:0] burst_count,
  input  logic             tick,
  output logic [DIV_W-1:0] half_q,
  output logic             clr,
  output logic             sample,
  output logic             publish,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy
);
  localparam int EC_W = $clog2(DW + 1);
  localparam int EL_W = $clog2(PWRUP_CLKS + 1);

  seq_st_t          st;
  frame_t           ftype, nxt_type;
  logic [EC_W-1:0]  edges;
  logic [EL_W-1:0]  elapsed;
  logic [Q_W-1:0]   qc, quiet_q;
  logic [CNT_W-1:0] left;
  logic             cont, stop_req, frame_done, more, gap_over;

  always_comb begin
    case (ftype)
      FR_CONV:  frame_done = (edges == EC_W'(DW));
      FR_SLEEP: frame_done = (edges == EC_W'(PD_EDGES));
      FR_WAKE:  frame_done = (edges == EC_W'(DW)) ||
                             ((edges >= EC_W'(WAKE_MIN)) &&
                              (elapsed >= EL_W'(PWRUP_CLKS - 1)));
      default:  frame_done = 1'b1;
    endcase
  end

  assign gap_over = (st == ST_QUIET) && (qc == quiet_q);
  assign more     = cont ? !(stop_req || cmd_stop) : (ftype != FR_SLEEP);
  assign nxt_type = (cont || left != '0) ? FR_CONV : FR_SLEEP;
  assign clr      = ((st == ST_IDLE) && cmd_valid) || (gap_over && more);
  assign sample   = (st == ST_HIGH) && tick;
  assign publish  = sample && (ftype == FR_CONV) && (edges == EC_W'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ftype    <= FR_CONV;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      busy     <= 1'b0;
      edges    <= '0;
      elapsed  <= '0;
      qc       <= '0;
      quiet_q  <= '0;
      half_q   <= DIV_W'(1);
      left     <= '0;
      cont     <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      if (busy && cmd_stop) stop_req <= 1'b1;
      if (!cs_n && elapsed != EL_W'(PWRUP_CLKS)) elapsed <= elapsed + EL_W'(1);
      case (st)
        ST_IDLE: if (cmd_valid) begin
          half_q   <= (div_half == '0) ? DIV_W'(1) : div_half;
          quiet_q  <= quiet_cycles;
          left     <= burst_count;
          cont     <= !cmd_burst;
          stop_req <= 1'b0;
          busy     <= 1'b1;
          ftype    <= cmd_burst ? FR_WAKE : FR_CONV;
          cs_n     <= 1'b0;
          sclk     <= 1'b1;
          edges    <= '0;
          elapsed  <= '0;
          st       <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk  <= 1'b0;
          edges <= edges + EC_W'(1);
          st    <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk <= 1'b1;
          if (frame_done) begin
            cs_n <= 1'b1;
            qc   <= '0;
            st   <= ST_QUIET;
          end else begin
            st <= ST_HIGH;
          end
        end
        ST_QUIET: begin
          if (gap_over) begin
            if (more) begin
              cs_n    <= 1'b0;
              edges   <= '0;
              elapsed <= '0;
              ftype   <= nxt_type;
              if (!cont && nxt_type == FR_CONV) left <= left - CNT_W'(1);
              st      <= ST_HIGH;
            end else begin
              busy <= 1'b0;
              st   <= ST_IDLE;
            end
          end else begin
            qc <= qc + Q_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_burst_sampler.sv
module adc_burst_sampler #(
  parameter int DW         = 16,
  parameter int DIV_W      = 8,
  parameter int Q_W        = 8,
  parameter int CNT_W      = 8,
  parameter int PWRUP_CLKS = 200,
  parameter int PD_EDGES   = 4,
  parameter int WAKE_MIN   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_burst,
  input  logic             cmd_stop,
  input  logic [DIV_W-1:0] div_half,
  input  logic [Q_W-1:0]   quiet_cycles,
  input  logic [CNT_W-1:0] burst_count,
  input  logic             adc_sdata,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic [DW-1:0]    result,
  output logic             result_valid,
  output logic             busy
);
  logic [DIV_W-1:0] half_q;
  logic             tick, clr, sample, publish;

  adcs_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .half(half_q), .tick(tick)
  );

  adcs_seq #(
    .DW(DW), .DIV_W(DIV_W), .Q_W(Q_W), .CNT_W(CNT_W),
    .PWRUP_CLKS(PWRUP_CLKS), .PD_EDGES(PD_EDGES), .WAKE_MIN(WAKE_MIN)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_burst(cmd_burst),
    .cmd_stop(cmd_stop), .div_half(div_half), .quiet_cycles(quiet_cycles),
    .burst_count(burst_count), .tick(tick), .half_q(half_q), .clr(clr),
    .sample(sample), .publish(publish), .cs_n(adc_cs_n), .sclk(adc_sclk),
    .busy(busy)
  );

  adcs_rx_shift #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .sample(sample), .publish(publish),
    .sdata(adc_sdata), .result(result), .valid(result_valid)
  );
endmodule

// File: rtl/adcs_sva.sv
module adcs_sva #(
  parameter int DW       = 16,
  parameter int Q_W      = 8,
  parameter int PD_EDGES = 4,
  parameter int WAKE_MIN = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic [Q_W-1:0] quiet_cycles,
  input logic           adc_cs_n,
  input logic           adc_sclk,
  input logic           result_valid,
  input logic           busy
);
  localparam int EC_W = $clog2(DW + 1);
  localparam int HC_W = Q_W + 1;

  logic [HC_W-1:0] hi_cnt;
  logic [Q_W-1:0]  q_lat;
  logic [EC_W-1:0] ecnt;
  logic            sclk_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      q_lat  <= '0;
      ecnt   <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= adc_sclk;
      cs_d   <= adc_cs_n;
      if (cmd_valid && !busy) q_lat <= quiet_cycles;
      if (adc_cs_n) begin
        if (hi_cnt != '1) hi_cnt <= hi_cnt + HC_W'(1);
      end else begin
        hi_cnt <= '0;
      end
      if (cs_d && !adc_cs_n) ecnt <= '0;
      else if (!adc_cs_n && sclk_d && !adc_sclk && ecnt != '1) ecnt <= ecnt + EC_W'(1);
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R4
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !adc_cs_n); // R4
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_cs_n) && $past(busy)) |-> (hi_cnt == HC_W'(q_lat) + HC_W'(1))); // R6
  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> ((ecnt == EC_W'(PD_EDGES)) ||
                         (ecnt >= EC_W'(WAKE_MIN) && ecnt <= EC_W'(DW)))); // R10
  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> busy); // R11
endmodule

bind adc_burst_sampler adcs_sva #(
  .DW(DW), .Q_W(Q_W), .PD_EDGES(PD_EDGES), .WAKE_MIN(WAKE_MIN)
) u_sva (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .quiet_cycles(quiet_cycles),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .result_valid(result_valid),
  .busy(busy)
);

// File: tb/sim_adc_burst_sampler.sv
`timescale 1ns/1ps
module sim_adc_burst_sampler;
  localparam int DW = 16, PD = 4, PWR = 200, WMIN = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_burst = 1'b0, cmd_stop = 1'b0;
  logic [7:0] div_half = 8'd1, quiet_cycles = 8'd0, burst_count = 8'd0;
  logic       adc_sdata = 1'b0;
  logic       adc_cs_n, adc_sclk, result_valid, busy;
  logic [15:0] result;

  adc_burst_sampler u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_burst(cmd_burst),
    .cmd_stop(cmd_stop), .div_half(div_half), .quiet_cycles(quiet_cycles),
    .burst_count(burst_count), .adc_sdata(adc_sdata), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .result(result), .result_valid(result_valid),
    .busy(busy)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int n);
    logic [31:0] x;
    x = n * 32'h9E3779B1 + 32'h1234567;
    return x[31:16] ^ x[15:0];
  endfunction

  function automatic int wake_len(input int h);
    int k;
    k = (PWR + 2 * h - 1) / (2 * h);
    if (k < WMIN) k = WMIN;
    if (k > DW) k = DW;
    return k;
  endfunction

  // converter model and protocol monitor
  logic        prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [15:0] cur_word = '0;
  int frame_no = 0, bit_idx = 0, edges = 0, hi_len = 0, lo_len = 0, sh_len = 0;
  int cmd_frames = 0, valid_cnt = 0, h_exp = 1, q_exp = 0;
  bit in_cmd = 0;
  int cmd_edges [0:63];

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !adc_cs_n) begin
        if (in_cmd && cmd_frames > 0) chk(hi_len == q_exp + 1, "R6 quiet gap", hi_len, q_exp + 1);
        frame_no++;
        cur_word = word_of(frame_no);
        bit_idx = 0; edges = 0; sh_len = 1;
        cmd_frames++;
      end else if (!prev_cs && adc_cs_n) begin
        if (cmd_frames >= 1 && cmd_frames <= 64) cmd_edges[cmd_frames-1] = edges;
        hi_len = 1;
      end else if (adc_cs_n) begin
        hi_len++;
      end
      if (prev_sclk && !adc_sclk) begin
        chk(sh_len == h_exp, "R3 high half", sh_len, h_exp);
        edges++; bit_idx++; lo_len = 1;
      end else if (!prev_sclk && adc_sclk) begin
        chk(lo_len == h_exp, "R3 low half", lo_len, h_exp);
        sh_len = 1;
      end else if (!adc_sclk) lo_len++;
      else if (!adc_cs_n && !(prev_cs && !adc_cs_n)) sh_len++;
      if (adc_cs_n) chk(adc_sclk == 1'b1, "R3 sclk parked", adc_sclk, 1);
      if (!adc_cs_n) chk(busy == 1'b1, "R11 busy during frame", busy, 1);
      if (result_valid) begin
        valid_cnt++;
        chk(result == cur_word, "R4 result word", result, cur_word);
      end
      adc_sdata = (bit_idx < 16) ? cur_word[15 - bit_idx] : 1'b0;
    end
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
  end

  task automatic run_cmd(input bit burst, input int div, input int q, input int n,
                         input int stop_after, input bit poke);
    int waited;
    @(negedge clk);
    cmd_burst = burst; div_half = 8'(div); quiet_cycles = 8'(q); burst_count = 8'(n);
    h_exp = (div == 0) ? 1 : div; q_exp = q;
    cmd_frames = 0; valid_cnt = 0; in_cmd = 1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    // R2: scramble configuration ports after acceptance
    div_half = 8'($urandom_range(1, 255));
    quiet_cycles = 8'($urandom);
    burst_count = 8'($urandom);
    cmd_burst = !burst;
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    if (!burst) begin
      waited = 0;
      while (cmd_frames < stop_after && waited < 40000) begin
        @(negedge clk); waited++;
      end
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
    end
    waited = 0;
    while (busy && waited < 40000) begin
      @(negedge clk); waited++;
    end
    chk(busy == 1'b0, "R11 command ends", busy, 0);
    chk(adc_cs_n == 1'b1, "R11 cs high when idle", adc_cs_n, 1);
    if (burst) begin
      chk(cmd_frames == n + 2, "R8 frame count", cmd_frames, n + 2);
      if (cmd_frames == n + 2 && cmd_frames <= 64) begin
        chk(cmd_edges[0] == wake_len(h_exp), "R9 wake edges", cmd_edges[0], wake_len(h_exp));
        for (int i = 1; i <= n; i++)
          chk(cmd_edges[i] == 16, "R5 burst conversion edges", cmd_edges[i], 16);
        chk(cmd_edges[n+1] == PD, "R10 sleep edges", cmd_edges[n+1], PD);
      end
      chk(valid_cnt == n, "R9 R10 valid count", valid_cnt, n);
    end else begin
      chk(cmd_frames == stop_after, "R7 frames before stop", cmd_frames, stop_after);
      for (int i = 0; i < cmd_frames && i < 64; i++)
        chk(cmd_edges[i] == 16, "R5 conversion edges", cmd_edges[i], 16);
      chk(valid_cnt == cmd_frames, "R4 valid count", valid_cnt, cmd_frames);
    end
    in_cmd = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 reset pins", {adc_cs_n, adc_sclk}, 3);
    chk(busy == 1'b0 && result_valid == 1'b0, "R1 reset status", {busy, result_valid}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && busy == 1'b0, "R1 after reset", {adc_cs_n, busy}, 2);
    // directed corner cases
    run_cmd(1'b1, 10, 3, 2, 0, 1'b0);  // R9 wake exactly at minimum
    run_cmd(1'b1, 12, 0, 1, 0, 1'b0);  // R9 power-up already covered, clamps to 10
    run_cmd(1'b1, 1, 2, 0, 0, 1'b0);   // R8 zero conversions, R9 capped at 16
    run_cmd(1'b1, 7, 5, 3, 0, 1'b1);   // R2 command during run ignored
    run_cmd(1'b0, 0, 0, 0, 1, 1'b0);   // R3 div 0 as 1, R7 single frame
    run_cmd(1'b0, 3, 4, 0, 3, 1'b1);   // R2 R7
    for (int i = 0; i < 18; i++) begin
      bit b;
      b = 1'($urandom_range(0, 1));
      run_cmd(b, $urandom_range(1, 8), $urandom_range(0, 15),
              $urandom_range(0, 5), $urandom_range(1, 4), 1'($urandom_range(0, 1)));
    end
    repeat (5) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule